// File: doc/BRIEF.md
# Indexed Stack and Pointer Unit

This unit carries out the memory-touching operations of a small processor whose index register holds four base pointers. It accepts one operation at a time (push, pop, indexed read, or indexed write with an optional swap-out of the old word), drives a synchronous single-port memory with one cycle of read latency, adjusts the chosen pointer and hands any fetched word to the destination-register side.

A three-bit selector names the pointer an operation works against. Stacks grow downward: a push writes below the pointer and moves the pointer down, and a pop reads at the pointer and moves it up. A pop whose destination is the index register itself leaves the pointer alone, so the freshly loaded value is not disturbed. Reads and writes add the chosen pointer to an operand address, or use the operand directly when the selector is zero. A write may also return the word it overwrites. That costs a read cycle before the store, and `busy_o` covers it. The index register can also be loaded directly through a small load port.

Top module: `idx_stack_unit`

## Requirements
- R1: After reset all four pointers equal the parameter `RST_PTR`, and `busy_o`, `done_o`, `err_o` and `rd_valid_o` are low.
- R2: The operation code is 0 push, 1 pop, 2 read, 3 write. Selector values 1, 2, 3, 4 choose the call-stack, code-frame, data-frame and local pointer, held in `ptr_o` slices 0, 1, 2, 3 (slice k at bits k*AW +: AW).
- R3: A push with a legal selector writes `req_data_i` at (pointer − 1) and leaves the pointer one lower. `done_o` is high in the cycle after acceptance, with `rd_valid_o` low.
- R4: A pop reads the word at the pointer. That word appears on `rd_data_o` with `rd_valid_o` and `done_o` two cycles after acceptance, and the pointer ends one higher.
- R5: A pop with `req_to_index_i` set returns the word as in R4 but leaves the pointer unchanged.
- R6: A read uses the address (operand + chosen pointer) modulo 2^AW for a selector of 1 to 4, and the operand alone for a selector of 0. The word returns as in R4 and no pointer changes.
- R7: A write with `req_ret_i` low stores `req_data_i` at the address rule of R6, completes in the cycle after acceptance and raises no `rd_valid_o`.
- R8: A write with `req_ret_i` high returns the word previously at the address two cycles after acceptance, stores `req_data_i` there, and holds `busy_o` high for the one cycle in between.
- R9: Push or pop with selector 0, or any operation with a selector above 4, raises `err_o` together with `done_o` in the cycle after acceptance. It makes no memory access and changes no pointer.
- R10: A request presented while `busy_o` is high is ignored. Any busy phase lasts exactly one cycle.
- R11: A load-port write sets the chosen pointer slice to `ld_val_i` on the next edge. If it hits the same pointer that an operation adjusts in that cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Operation request, taken when not busy |
| req_op_i | input | 2 | Operation code (R2) |
| req_sel_i | input | 3 | Pointer selector, 0 to 4 legal |
| req_operand_i | input | AW | Operand address for read and write |
| req_data_i | input | DW | Data to push or write |
| req_ret_i | input | 1 | Write returns the old word |
| req_to_index_i | input | 1 | Pop destination is the index register |
| ld_en_i | input | 1 | Direct pointer load strobe |
| ld_idx_i | input | 2 | Pointer slice to load |
| ld_val_i | input | AW | Value to load |
| busy_o | output | 1 | Second cycle of a two-cycle operation |
| done_o | output | 1 | Operation finished this cycle |
| err_o | output | 1 | Operation rejected as illegal |
| rd_valid_o | output | 1 | `rd_data_o` carries a returned word |
| rd_data_o | output | DW | Returned word for the destination |
| ptr_o | output | 4*AW | The four pointers, slice 0 first |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Read data, one cycle after the read strobe |

## Verification
The assertions assume that the memory answers every read strobe with valid data on the next cycle and that the request and load inputs are low during reset; the bench's memory model is a registered array that does exactly this. Stimulus draws operations, selectors (mostly legal, sometimes 0 or above 4), operands, data, return flags and occasional simultaneous pointer loads from a seeded generator. Every request goes in while the unit is idle, except a directed case that pokes a request during the busy cycle. All addresses wrap inside a memory of 2^AW words, so any pointer value is a legal target.

// File: rtl/isu_pkg.sv
package isu_pkg;

    typedef enum logic [1:0] {
        OP_PUSH  = 2'd0,
        OP_POP   = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } isu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SWAP  = 2'd2
    } isu_state_e;

endpackage

// File: rtl/isu_addr_calc.sv
module isu_addr_calc
    import isu_pkg::*;
#(
    parameter int AW   = 10,
    parameter int NPTR = 4,
    parameter int SW   = 3,
    parameter int IW   = 2
) (
    input  logic [1:0]               op_i,
    input  logic [SW-1:0]            sel_i,
    input  logic [AW-1:0]            operand_i,
    input  logic [NPTR-1:0][AW-1:0]  ptrs_i,
    output logic [AW-1:0]            addr_o,
    output logic [IW-1:0]            idx_o,
    output logic                     legal_o
);

    logic          sel_hit;
    logic [AW-1:0] base;
    logic          stack_op;

    always_comb begin
        sel_hit = 1'b0;
        base    = '0;
        idx_o   = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (int'(sel_i) == i + 1) begin
                sel_hit = 1'b1;
                base    = ptrs_i[i];
                idx_o   = IW'(i);
            end
        end
        stack_op = (op_i == OP_PUSH) || (op_i == OP_POP);
        legal_o  = stack_op ? sel_hit : (sel_hit || (sel_i == '0));
        unique case (op_i)
            OP_PUSH: addr_o = base - AW'(1);
            OP_POP:  addr_o = base;
            default: addr_o = operand_i + base;
        endcase
    end

endmodule

// File: rtl/isu_ptr_bank.sv
module isu_ptr_bank #(
    parameter int AW      = 10,
    parameter int NPTR    = 4,
    parameter int IW      = 2,
    parameter int RST_PTR = 0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     step_en_i,
    input  logic                     step_up_i,
    input  logic [IW-1:0]            step_idx_i,
    input  logic                     ld_en_i,
    input  logic [IW-1:0]            ld_idx_i,
    input  logic [AW-1:0]            ld_val_i,
    output logic [NPTR-1:0][AW-1:0]  ptrs_o
);

    logic [NPTR-1:0][AW-1:0] ptr_d, ptr_q;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        always_comb begin
            ptr_d[g] = ptr_q[g];
            if (step_en_i && (int'(step_idx_i) == g)) begin
                ptr_d[g] = step_up_i ? ptr_q[g] + AW'(1) : ptr_q[g] - AW'(1);
            end
            if (ld_en_i && (int'(ld_idx_i) == g)) begin
                ptr_d[g] = ld_val_i;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                ptr_q[g] <= AW'(RST_PTR);
            end else begin
                ptr_q[g] <= ptr_d[g];
            end
        end
    end

    assign ptrs_o = ptr_q;

    // R4
    ptr_step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && step_up_i && !(ld_en_i && ld_idx_i == step_idx_i))
        |=> ptr_q[$past(step_idx_i)] == $past(ptr_q[step_idx_i]) + AW'(1));

    // R3
    ptr_step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_en_i && !step_up_i && !(ld_en_i && ld_idx_i == step_idx_i))
        |=> ptr_q[$past(step_idx_i)] == $past(ptr_q[step_idx_i]) - AW'(1));

    // R11
    ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_en_i |=> ptr_q[$past(ld_idx_i)] == $past(ld_val_i));

endmodule

// File: rtl/idx_stack_unit.sv
module idx_stack_unit
    import isu_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 32,
    parameter int NPTR    = 4,
    parameter int RST_PTR = 0,
    localparam int SW     = $clog2(NPTR + 1),
    localparam int IW     = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    input  logic [1:0]           req_op_i,
    input  logic [SW-1:0]        req_sel_i,
    input  logic [AW-1:0]        req_operand_i,
    input  logic [DW-1:0]        req_data_i,
    input  logic                 req_ret_i,
    input  logic                 req_to_index_i,
    input  logic                 ld_en_i,
    input  logic [IW-1:0]        ld_idx_i,
    input  logic [AW-1:0]        ld_val_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic                 rd_valid_o,
    output logic [DW-1:0]        rd_data_o,
    output logic [NPTR*AW-1:0]   ptr_o,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic [AW-1:0]        mem_addr_o,
    output logic [DW-1:0]        mem_wdata_o,
    input  logic [DW-1:0]        mem_rdata_i
);

    typedef struct packed {
        isu_state_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          done;
        logic          err;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NPTR-1:0][AW-1:0] ptrs;
    logic [AW-1:0]           calc_addr;
    logic [IW-1:0]           calc_idx;
    logic                    calc_legal;
    logic                    step_en;
    logic                    step_up;

    isu_addr_calc #(
        .AW   (AW),
        .NPTR (NPTR),
        .SW   (SW),
        .IW   (IW)
    ) addr_i (
        .op_i      (req_op_i),
        .sel_i     (req_sel_i),
        .operand_i (req_operand_i),
        .ptrs_i    (ptrs),
        .addr_o    (calc_addr),
        .idx_o     (calc_idx),
        .legal_o   (calc_legal)
    );

    isu_ptr_bank #(
        .AW      (AW),
        .NPTR    (NPTR),
        .IW      (IW),
        .RST_PTR (RST_PTR)
    ) bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_en_i  (step_en),
        .step_up_i  (step_up),
        .step_idx_i (calc_idx),
        .ld_en_i    (ld_en_i),
        .ld_idx_i   (ld_idx_i),
        .ld_val_i   (ld_val_i),
        .ptrs_o     (ptrs)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done   = 1'b0;
        ctl_d.err    = 1'b0;
        ctl_d.rvalid = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = calc_addr;
        mem_wdata_o  = req_data_i;
        step_en      = 1'b0;
        step_up      = 1'b0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (!calc_legal) begin
                        ctl_d.done = 1'b1;
                        ctl_d.err  = 1'b1;
                    end else begin
                        unique case (req_op_i)
                            OP_PUSH: begin
                                mem_req_o  = 1'b1;
                                mem_we_o   = 1'b1;
                                step_en    = 1'b1;
                                ctl_d.done = 1'b1;
                            end
                            OP_POP: begin
                                mem_req_o = 1'b1;
                                step_en   = !req_to_index_i;
                                step_up   = 1'b1;
                                ctl_d.st  = ST_FETCH;
                            end
                            OP_READ: begin
                                mem_req_o = 1'b1;
                                ctl_d.st  = ST_FETCH;
                            end
                            default: begin
                                mem_req_o = 1'b1;
                                if (req_ret_i) begin
                                    ctl_d.st    = ST_SWAP;
                                    ctl_d.addr  = calc_addr;
                                    ctl_d.wdata = req_data_i;
                                end else begin
                                    mem_we_o   = 1'b1;
                                    ctl_d.done = 1'b1;
                                end
                            end
                        endcase
                    end
                end
            end
            ST_FETCH: begin
                ctl_d.rvalid = 1'b1;
                ctl_d.rdata  = mem_rdata_i;
                ctl_d.done   = 1'b1;
                ctl_d.st     = ST_IDLE;
            end
            default: begin
                mem_req_o    = 1'b1;
                mem_we_o     = 1'b1;
                mem_addr_o   = ctl_q.addr;
                mem_wdata_o  = ctl_q.wdata;
                ctl_d.rvalid = 1'b1;
                ctl_d.rdata  = mem_rdata_i;
                ctl_d.done   = 1'b1;
                ctl_d.st     = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o     = (ctl_q.st != ST_IDLE);
    assign done_o     = ctl_q.done;
    assign err_o      = ctl_q.err;
    assign rd_valid_o = ctl_q.rvalid;
    assign rd_data_o  = ctl_q.rdata;
    assign ptr_o      = ptrs;

    // R10
    busy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> !busy_o);

    // R8
    busy_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (done_o && rd_valid_o));

    // R9
    err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (done_o && !rd_valid_o));

    // R9
    err_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !$past(mem_req_o));

    // R4
    rvalid_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_valid_o |-> done_o);

endmodule

// File: tb/idx_stack_unit_tb_top.sv
module idx_stack_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 10;
    localparam int DW   = 32;
    localparam int NPTR = 4;
    localparam int MEMN = 1 << AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [1:0]          req_op = '0;
    logic [2:0]          req_sel = '0;
    logic [AW-1:0]       req_operand = '0;
    logic [DW-1:0]       req_data = '0;
    logic                req_ret = 1'b0;
    logic                req_to_index = 1'b0;
    logic                ld_en = 1'b0;
    logic [1:0]          ld_idx = '0;
    logic [AW-1:0]       ld_val = '0;
    logic                busy, done, err, rd_valid;
    logic [DW-1:0]       rd_data;
    logic [NPTR*AW-1:0]  ptr_vec;
    logic                mem_req, mem_we;
    logic [AW-1:0]       mem_addr;
    logic [DW-1:0]       mem_wdata;
    logic [DW-1:0]       mem_rd_q;

    logic [DW-1:0] mem_arr [MEMN];
    logic [DW-1:0] exp_mem [MEMN];
    logic [AW-1:0] exp_ptr [NPTR];

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_stack_unit #(.AW(AW), .DW(DW), .NPTR(NPTR), .RST_PTR(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_sel_i(req_sel),
        .req_operand_i(req_operand), .req_data_i(req_data),
        .req_ret_i(req_ret), .req_to_index_i(req_to_index),
        .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_val_i(ld_val),
        .busy_o(busy), .done_o(done), .err_o(err),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .ptr_o(ptr_vec),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rd_q)
    );

    function automatic logic [DW-1:0] seed_word(int i);
        return 32'h5A00_0000 ^ (i * 32'h0000_9E37);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMN; i++) mem_arr[i] <= seed_word(i);
            mem_rd_q <= '0;
        end else if (mem_req) begin
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else        mem_rd_q <= mem_arr[mem_addr];
        end
    end

    function automatic bit sel_legal(int op, int sel);
        if (op <= 1) return (sel >= 1 && sel <= NPTR);
        return (sel <= NPTR);
    endfunction

    function automatic logic [AW-1:0] calc_addr(int op, int sel, logic [AW-1:0] opnd);
        logic [AW-1:0] base;
        base = (sel >= 1 && sel <= NPTR) ? exp_ptr[sel-1] : '0;
        if (op == 0) return base - AW'(1);
        if (op == 1) return base;
        return opnd + base;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_ptrs(string tag);
        for (int k = 0; k < NPTR; k++) begin
            check(ptr_vec[k*AW +: AW] == exp_ptr[k], tag, $sformatf("ptr slice %0d", k),
                  longint'(ptr_vec[k*AW +: AW]), longint'(exp_ptr[k]));
        end
    endtask

    task automatic check_mem(string tag);
        int diffs = 0;
        int first = -1;
        for (int i = 0; i < MEMN; i++) begin
            if (mem_arr[i] !== exp_mem[i]) begin
                diffs++;
                if (first < 0) first = i;
            end
        end
        check(diffs == 0, tag, "memory image mismatches (count vs 0)", longint'(diffs), 0);
    endtask

    // One operation; optional concurrent load and optional poke during busy.
    task automatic run_op(string tag, int op, int sel, logic [AW-1:0] opnd,
                          logic [DW-1:0] data, bit ret, bit to_idx,
                          bit ld, int lidx, logic [AW-1:0] lval, bit poke);
        bit legal;
        logic [AW-1:0] a;
        int exp_lat;
        bit exp_rv;
        logic [DW-1:0] exp_rd;
        int cyc;
        legal  = sel_legal(op, sel);
        a      = calc_addr(op, sel, opnd);
        exp_rv = 1'b0;
        exp_rd = '0;
        exp_lat = 1;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_sel = 3'(sel);
        req_operand = opnd; req_data = data; req_ret = ret; req_to_index = to_idx;
        ld_en = ld; ld_idx = 2'(lidx); ld_val = lval;
        if (legal) begin
            case (op)
                0: begin exp_mem[a] = data; exp_ptr[sel-1] = exp_ptr[sel-1] - AW'(1); end
                1: begin exp_rv = 1; exp_rd = exp_mem[a]; exp_lat = 2;
                         if (!to_idx) exp_ptr[sel-1] = exp_ptr[sel-1] + AW'(1); end
                2: begin exp_rv = 1; exp_rd = exp_mem[a]; exp_lat = 2; end
                default: begin
                    if (ret) begin exp_rv = 1; exp_rd = exp_mem[a]; exp_lat = 2; end
                    exp_mem[a] = data;
                end
            endcase
        end
        if (ld) exp_ptr[lidx] = lval;
        @(negedge clk);
        req_valid = 1'b0; ld_en = 1'b0;
        cyc = 1;
        if (!done) begin
            check(busy == 1'b1, tag, "busy during second cycle", busy, 1);
            if (poke) begin
                req_valid = 1'b1; req_op = 2'd0; req_sel = 3'd1; req_data = 32'hDEAD_BEEF;
            end
        end
        while (!done && cyc < 6) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
        end
        check(cyc == exp_lat, tag, "completion latency", cyc, exp_lat);
        check(err == !legal, tag, "err flag", err, !legal);
        check(rd_valid == exp_rv, tag, "rd_valid", rd_valid, exp_rv);
        if (exp_rv) check(rd_data == exp_rd, tag, "returned word", rd_data, exp_rd);
        check_ptrs(tag);
        check_mem(tag);
    endtask

    task automatic load_ptr(int idx, logic [AW-1:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 2'(idx); ld_val = val;
        exp_ptr[idx] = val;
        @(negedge clk);
        ld_en = 1'b0;
        check_ptrs("R11");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E_7A11));
        for (int i = 0; i < MEMN; i++) exp_mem[i] = seed_word(i);
        for (int k = 0; k < NPTR; k++) exp_ptr[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && err == 0 && rd_valid == 0, "R1", "status flags",
              {busy, done, err, rd_valid}, 0);
        check_ptrs("R1");

        // R11 direct loads
        load_ptr(0, 10'd100);
        load_ptr(1, 10'd200);
        load_ptr(2, 10'd300);
        load_ptr(3, 10'd400);

        // R2 / R3 pushes to call stack and local pointer
        run_op("R3", 0, 1, '0, 32'hAAAA_0001, 0, 0, 0, 0, '0, 0);
        run_op("R2", 0, 4, '0, 32'hBBBB_0004, 0, 0, 0, 0, '0, 0);
        // R4 pop returns the pushed word
        run_op("R4", 1, 1, '0, '0, 0, 0, 0, 0, '0, 0);
        // R5 pop into index register keeps pointer
        run_op("R5", 1, 4, '0, '0, 0, 1, 0, 0, '0, 0);
        // R6 reads: bare, offset, wrapping
        run_op("R6", 2, 0, 10'd55, '0, 0, 0, 0, 0, '0, 0);
        run_op("R6", 2, 3, 10'd10, '0, 0, 0, 0, 0, '0, 0);
        run_op("R6", 2, 2, 10'd1000, '0, 0, 0, 0, 0, '0, 0);
        // R7 plain write, R8 swap write
        run_op("R7", 3, 3, 10'd7, 32'hCAFE_0007, 0, 0, 0, 0, '0, 0);
        run_op("R8", 3, 0, 10'd310, 32'h1234_5678, 1, 0, 0, 0, '0, 0);
        run_op("R8", 3, 0, 10'd310, 32'h8765_4321, 1, 0, 0, 0, '0, 0);
        // R9 illegal selectors
        run_op("R9", 0, 0, '0, 32'h1111_1111, 0, 0, 0, 0, '0, 0);
        run_op("R9", 1, 0, '0, '0, 0, 0, 0, 0, '0, 0);
        run_op("R9", 2, 5, 10'd3, '0, 0, 0, 0, 0, '0, 0);
        run_op("R9", 3, 7, 10'd3, 32'h2222_2222, 1, 0, 0, 0, '0, 0);
        // R10 request during busy is ignored
        run_op("R10", 1, 2, '0, '0, 0, 0, 0, 0, '0, 1);
        run_op("R10", 3, 4, 10'd9, 32'h3333_3333, 1, 0, 0, 0, '0, 1);
        // R11 load beats concurrent pointer update
        run_op("R11", 0, 2, '0, 32'h4444_4444, 0, 0, 1, 1, 10'd600, 0);
        run_op("R11", 1, 3, '0, '0, 0, 0, 1, 2, 10'd20, 0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op, sel, lidx;
            bit ret, toi, ld;
            op   = int'($urandom_range(0, 3));
            sel  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 7))
                                               : int'($urandom_range(1, 4));
            ret  = 1'($urandom_range(0, 1));
            toi  = (op == 1) && ($urandom_range(0, 4) == 0);
            ld   = ($urandom_range(0, 9) == 0);
            lidx = int'($urandom_range(0, 3));
            run_op(op == 0 ? "R3" : op == 1 ? (toi ? "R5" : "R4") : op == 2 ? "R6" :
                   (ret ? "R8" : "R7"),
                   op, sel, AW'($urandom), $urandom, ret, toi, ld, lidx, AW'($urandom), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule